// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block produces the output side of a synchronous read from a small memory array. A host presents an address, pulls the address strobe low while the chip select is active, and the block captures the address on the next active clock edge. It then holds the WAIT line active for a programmable initial latency and streams words out. Each word's address follows an order chosen at run time, and each word stays on the bus for one or two clocks. A host that sees WAIT inactive together with the valid flag takes the word on the bus.

A 16-bit configuration word sets the latency, the burst length (4, 8 or endless), sequential or interleaved order inside the block, wrapping or linear addressing, the data hold time, the WAIT polarity and which clock edge is active. A single-read flag turns any access into a one-word read that uses only the latency setting. In endless mode the block inserts one extra data period of WAIT the first time the address sequence reaches a 64-word boundary, unless the start address was a multiple of four. Raising the chip select ends any access at once.

The output is a stream with no back-pressure: the memory cannot pause, so the consumer must accept every word while `rd_valid` is high. A word held for two clocks counts as one word that is visible for two cycles. WAIT is the only flow indicator toward the host.

Top module: `burst_read_seq`

## Requirements
- R1: With `chip_sel_n` low and `addr_strobe_n` low at an active edge, the block captures `rd_addr` and the configuration. From that edge on, WAIT is active and `rd_valid` is low. The first word is valid exactly L active edges after the capturing edge. L is `cfg[13:11]`, with values below 2 taken as 2 and values above 5 taken as 5.
- R2: `cfg[2:0]` = 3'b001 gives 4 words and 3'b010 gives 8 words. Every other code gives an endless burst. After the last word of a finite burst, `rd_valid` is low and WAIT is inactive until the next start.
- R3: `cfg[3]` = 0 keeps the addresses inside the aligned 4- or 8-word block that holds the start address, counting upward and wrapping. `cfg[3]` = 1 gives linear addresses start+k. Endless bursts are always linear.
- R4: `cfg[7]` = 1 with wrapping and a finite length gives the in-block offset (start offset XOR k). With no-wrap or endless length, `cfg[7]` is ignored and the order is sequential.
- R5: `cfg[9]` = 0 holds each word for one clock and `cfg[9]` = 1 holds it for two. During the hold, `rd_data` is stable and `rd_valid` stays high.
- R6: In an endless burst whose start address is not a multiple of 4, the first word whose address has its low 6 bits zero is preceded by one extra data period (1 or 2 clocks) with WAIT active and `rd_valid` low. No other stall occurs.
- R7: WAIT appears on `wait_sig` at level `cfg[10]` when active and at the inverse level when inactive. 1 is the default. WAIT is never active while `rd_valid` is high.
- R8: With `single_rd` high at the start, exactly one word, the start address, is valid for one clock after latency L. Length, order, wrap and hold settings have no effect.
- R9: `chip_sel_n` high at an active edge makes `rd_valid` low and WAIT inactive after that edge, whatever the access was doing.
- R10: A new start during any phase of a burst abandons the old one and begins again from R1.
- R11: `cfg[6]` = 1 makes the rising clock edge active and `cfg[6]` = 0 makes the falling edge active. The field may change only while `rst_n` is low.
- R12: The word at address a is the low 16 bits of (a·40503 + 4660) mod 2^32. Addresses run modulo 2^AW.
- R13: While `rst_n` is low, `rd_valid` is low and WAIT is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; active edge chosen by cfg[6] |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | AW | Start address captured at a start |
| addr_strobe_n | input | 1 | Address strobe, active low; starts an access |
| chip_sel_n | input | 1 | Chip select, active low; high aborts |
| single_rd | input | 1 | One-word read when high at the start |
| cfg | input | 16 | Run-time configuration word |
| rd_data | output | DW | Output word |
| rd_valid | output | 1 | Output word valid |
| wait_sig | output | 1 | WAIT, polarity set by cfg[10] |

## Verification
After a capturing edge, WAIT is active on the very next output update. Word k of a burst lands L + k·P active edges later, where P is the hold period, plus P more edges once the R6 stall has happened. An abort takes effect one active edge after `chip_sel_n` rises. A polarity change on `cfg[10]` shows on `wait_sig` combinationally. The bench reference model steps a queue of expected output slots at each active edge. It compares outputs half a clock later, at the inactive edge, and changes inputs one nanosecond after that comparison, so every sample falls between edges.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int CFG_W     = 16;
  localparam int LEN_LO    = 0;
  localparam int WRAP_BIT  = 3;
  localparam int EDGE_BIT  = 6;
  localparam int ORDER_BIT = 7;
  localparam int HOLD_BIT  = 9;
  localparam int POL_BIT   = 10;
  localparam int LAT_LO    = 11;
  localparam int BOUND_W   = 6;   // 64-word stall boundary

  typedef enum logic [2:0] {
    ST_IDLE, ST_LAT, ST_DATA, ST_STALL, ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [3:0] len;   // words per burst, 0 = endless
    logic       ilv;   // interleaved in-block order
    logic       lin;   // linear addressing
  } addr_mode_t;

  typedef struct packed {
    addr_mode_t am;
    logic [2:0] lat;   // initial latency, 2..5
    logic       hold2; // two-cycle data period
  } mode_t;
endpackage

// File: rtl/bsq_cfg_decode.sv
module bsq_cfg_decode
  import bsq_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic             single_rd,
  output mode_t            mode
);
  logic [2:0] lat_raw;
  logic       endless;
  logic       cfg_unused;

  assign cfg_unused = ^{cfg[15:14], cfg[8], cfg[6:4]};

  always_comb begin
    mode    = '0;
    lat_raw = cfg[LAT_LO +: 3];
    if (lat_raw < 3'd2)      mode.lat = 3'd2;
    else if (lat_raw > 3'd5) mode.lat = 3'd5;
    else                     mode.lat = lat_raw;

    endless = 1'b0;
    case (cfg[LEN_LO +: 3])
      3'b001:  mode.am.len = 4'd4;
      3'b010:  mode.am.len = 4'd8;
      default: begin
        mode.am.len = 4'd0;
        endless     = 1'b1;
      end
    endcase

    if (single_rd) begin
      mode.am.len = 4'd1;
      mode.am.lin = 1'b1;
      mode.am.ilv = 1'b0;
      mode.hold2  = 1'b0;
    end else begin
      mode.am.lin = endless | cfg[WRAP_BIT];
      mode.am.ilv = cfg[ORDER_BIT] & ~mode.am.lin;
      mode.hold2  = cfg[HOLD_BIT];
    end
  end
endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen
  import bsq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] idx,
  input  addr_mode_t    am,
  output logic [AW-1:0] word_addr
);
  logic [AW-1:0] lin_a;
  logic [AW-1:0] mask_w;
  logic [2:0]    mask, low_seq, low_ilv, low_sel;

  always_comb begin
    lin_a   = start + idx;
    mask    = (am.len == 4'd8) ? 3'b111 : 3'b011;
    mask_w  = {{(AW-3){1'b0}}, mask};
    low_seq = start[2:0] + idx[2:0];
    low_ilv = start[2:0] ^ idx[2:0];
    low_sel = am.ilv ? low_ilv : low_seq;
    if (am.lin) word_addr = lin_a;
    else        word_addr = (start & ~mask_w) | {{(AW-3){1'b0}}, low_sel & mask};
  end
endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
  import bsq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n,
  input  logic          chip_n,
  input  logic [AW-1:0] addr_in,
  input  mode_t         mode_in,
  input  logic          at_bound,
  input  logic [DW-1:0] word_data,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] idx_q,
  output addr_mode_t    am_q,
  output logic [DW-1:0] data_q,
  output logic          valid_q,
  output logic          wait_q
);
  localparam logic [AW-1:0] IDX_ONE = {{(AW-1){1'b0}}, 1'b1};

  seq_state_e st_q;
  logic [2:0] lat_cnt_q;
  logic       hold_q, hold2_q, crossed_q, unaligned_q;
  logic       burst_end, stall_here;

  always_comb begin
    burst_end  = (am_q.len != 4'd0) && (idx_q == {{(AW-4){1'b0}}, am_q.len});
    stall_here = (am_q.len == 4'd0) && unaligned_q && !crossed_q && at_bound;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      start_q     <= '0;
      idx_q       <= '0;
      am_q        <= '0;
      data_q      <= '0;
      valid_q     <= 1'b0;
      wait_q      <= 1'b0;
      lat_cnt_q   <= '0;
      hold_q      <= 1'b0;
      hold2_q     <= 1'b0;
      crossed_q   <= 1'b0;
      unaligned_q <= 1'b0;
    end else if (chip_n) begin
      st_q    <= ST_IDLE;
      valid_q <= 1'b0;
      wait_q  <= 1'b0;
    end else if (!strobe_n) begin
      st_q        <= ST_LAT;
      start_q     <= addr_in;
      am_q        <= mode_in.am;
      hold2_q     <= mode_in.hold2;
      idx_q       <= '0;
      lat_cnt_q   <= mode_in.lat - 3'd1;
      hold_q      <= 1'b0;
      crossed_q   <= 1'b0;
      unaligned_q <= |addr_in[1:0];
      valid_q     <= 1'b0;
      wait_q      <= 1'b1;
    end else begin
      case (st_q)
        ST_LAT: begin
          if (lat_cnt_q == 3'd0) begin
            data_q  <= word_data;
            valid_q <= 1'b1;
            wait_q  <= 1'b0;
            hold_q  <= hold2_q;
            idx_q   <= idx_q + IDX_ONE;
            st_q    <= ST_DATA;
          end else begin
            lat_cnt_q <= lat_cnt_q - 3'd1;
          end
        end
        ST_DATA: begin
          if (hold_q) begin
            hold_q <= 1'b0;
          end else if (burst_end) begin
            st_q    <= ST_DONE;
            valid_q <= 1'b0;
            wait_q  <= 1'b0;
          end else if (stall_here) begin
            st_q      <= ST_STALL;
            valid_q   <= 1'b0;
            wait_q    <= 1'b1;
            hold_q    <= hold2_q;
            crossed_q <= 1'b1;
          end else begin
            data_q  <= word_data;
            valid_q <= 1'b1;
            wait_q  <= 1'b0;
            hold_q  <= hold2_q;
            idx_q   <= idx_q + IDX_ONE;
          end
        end
        ST_STALL: begin
          if (hold_q) begin
            hold_q <= 1'b0;
          end else begin
            data_q  <= word_data;
            valid_q <= 1'b1;
            wait_q  <= 1'b0;
            hold_q  <= hold2_q;
            idx_q   <= idx_q + IDX_ONE;
            st_q    <= ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import bsq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  input  logic             addr_strobe_n,
  input  logic             chip_sel_n,
  input  logic             single_rd,
  input  logic [CFG_W-1:0] cfg,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             wait_sig
);
  logic          act_clk;
  mode_t         mode_live;
  addr_mode_t    am_q;
  logic [AW-1:0] start_q, idx_q, word_addr;
  logic [DW-1:0] word_data;
  logic          at_bound, wait_q;

  // active edge select; cfg[EDGE_BIT] changes only under reset
  assign act_clk = cfg[EDGE_BIT] ? clk : ~clk;

  bsq_cfg_decode u_dec (
    .cfg       (cfg),
    .single_rd (single_rd),
    .mode      (mode_live)
  );

  bsq_addr_gen #(.AW(AW)) u_agen (
    .start     (start_q),
    .idx       (idx_q),
    .am        (am_q),
    .word_addr (word_addr)
  );

  assign at_bound  = (word_addr[BOUND_W-1:0] == '0);
  assign word_data = DW'(32'(word_addr) * 32'd40503 + 32'd4660);

  bsq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk       (act_clk),
    .rst_n     (rst_n),
    .strobe_n  (addr_strobe_n),
    .chip_n    (chip_sel_n),
    .addr_in   (rd_addr),
    .mode_in   (mode_live),
    .at_bound  (at_bound),
    .word_data (word_data),
    .start_q   (start_q),
    .idx_q     (idx_q),
    .am_q      (am_q),
    .data_q    (rd_data),
    .valid_q   (rd_valid),
    .wait_q    (wait_q)
  );

  assign wait_sig = wait_q ? cfg[POL_BIT] : ~cfg[POL_BIT];
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int DW = 16
) (
  input logic          act_clk,
  input logic          rst_n,
  input logic          strobe_n,
  input logic          chip_n,
  input logic          single_rd,
  input logic          hold_sel,
  input logic          pol_sel,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          wait_sig
);
  logic wait_on;
  assign wait_on = (wait_sig == pol_sel);

  // R7
  valid_wait_excl_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    rd_valid |-> !wait_on);

  // R9
  abort_idle_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    chip_n |=> (!rd_valid && !wait_on));

  // R1
  start_wait_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    (!chip_n && !strobe_n) |=> (!rd_valid && wait_on));

  // R5
  hold_two_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    ($rose(rd_valid) && hold_sel && !single_rd && !chip_n && strobe_n)
      |=> (rd_valid && $stable(rd_data)));

  // R8
  single_one_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    (rd_valid && single_rd && !chip_n && strobe_n) |=> !rd_valid);
endmodule

bind burst_read_seq bsq_checker #(.DW(DW)) u_chk (
  .act_clk   (act_clk),
  .rst_n     (rst_n),
  .strobe_n  (addr_strobe_n),
  .chip_n    (chip_sel_n),
  .single_rd (single_rd),
  .hold_sel  (cfg[9]),
  .pol_sel   (cfg[10]),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .wait_sig  (wait_sig)
);

// File: tb/sim_burst_read_seq.sv
`timescale 1ns/1ps
module sim_burst_read_seq;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          addr_strobe_n = 1'b1;
  logic          chip_sel_n = 1'b1;
  logic          single_rd = 1'b0;
  logic [15:0]   cfg = 16'h1441;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          wait_sig;

  always #2.5 clk = ~clk;

  burst_read_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .addr_strobe_n(addr_strobe_n),
    .chip_sel_n(chip_sel_n), .single_rd(single_rd), .cfg(cfg),
    .rd_data(rd_data), .rd_valid(rd_valid), .wait_sig(wait_sig)
  );

  typedef struct { bit v; bit w; logic [DW-1:0] d; } slot_t;
  localparam slot_t IDLE = '{1'b0, 1'b0, '0};
  localparam slot_t WAITING = '{1'b0, 1'b1, '0};

  slot_t q[$];
  slot_t exp_s = IDLE;
  int    checks = 0, fails = 0;
  string req = "R13";
  bit    done = 1'b0;

  // R12 memory content
  function automatic logic [DW-1:0] mem_word(int a);
    logic [31:0] t;
    t = 32'(a % DEPTH) * 32'd40503 + 32'd4660;
    return t[DW-1:0];
  endfunction

  // expected slot sequence from R1..R8
  task automatic plan_burst();
    int lat, n, p, a0, a, blk, base, lo;
    bit endless, lin, ilv, stalled;
    q.delete();
    a0  = int'(rd_addr);
    lat = int'(cfg[13:11]);
    if (lat < 2) lat = 2;
    if (lat > 5) lat = 5;
    case (cfg[2:0])
      3'b001:  n = 4;
      3'b010:  n = 8;
      default: n = 0;
    endcase
    endless = (n == 0);
    p   = cfg[9] ? 2 : 1;
    lin = endless || cfg[3];
    ilv = cfg[7] && !lin;
    if (single_rd) begin n = 1; endless = 0; p = 1; lin = 1; ilv = 0; end
    for (int i = 0; i < lat; i++) q.push_back(WAITING);
    stalled = 0;
    for (int k = 0; k < (endless ? 300 : n); k++) begin
      if (lin) a = (a0 + k) % DEPTH;
      else begin
        blk  = n;
        base = a0 - (a0 % blk);
        lo   = ilv ? ((a0 % blk) ^ k) : (((a0 % blk) + k) % blk);
        a    = base + lo;
      end
      if (endless && !stalled && k > 0 && (a0 % 4) != 0 && (a % 64) == 0) begin
        stalled = 1;
        repeat (p) q.push_back(WAITING);
      end
      repeat (p) q.push_back('{1'b1, 1'b0, mem_word(a)});
    end
  endtask

  task automatic compare();
    slot_t e;
    logic  wl;
    bit    ok;
    e  = rst_n ? exp_s : IDLE;
    wl = e.w ? cfg[10] : ~cfg[10];
    ok = (rd_valid === e.v) && (wait_sig === wl) && (!e.v || rd_data === e.d);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t: valid=%0b wait=%0b data=%h expected valid=%0b wait=%0b data=%h",
               req, $time, rd_valid, wait_sig, rd_data, e.v, wl, e.d);
    end
  endtask

  // reference model steps at the active edge, compares at the other
  always @(clk) begin
    if ((clk == 1'b1) == cfg[6]) begin
      if (!rst_n || chip_sel_n) begin
        q.delete();
        exp_s = IDLE;
      end else begin
        if (!addr_strobe_n) plan_burst();
        if (q.size() > 0) exp_s = q.pop_front();
        else exp_s = IDLE;
      end
    end else if (!done) begin
      compare();
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin
      if (cfg[6]) @(negedge clk);
      else @(posedge clk);
      #1;
    end
  endtask

  task automatic run_burst(string r, logic [15:0] c, int a, bit s, int cycles);
    req = r; cfg = c; rd_addr = AW'(a); single_rd = s;
    chip_sel_n = 1'b0; addr_strobe_n = 1'b0;
    step();
    addr_strobe_n = 1'b1;
    step(cycles);
    chip_sel_n = 1'b1;
    step(2);
  endtask

  initial begin
    // R13 reset state
    req = "R13";
    step(4);
    rst_n = 1'b1;
    step(2);
    // R1 R3 wrapped sequential, latency 2
    run_burst("R1", 16'h1441, 8'h05, 0, 12);
    // R4 interleaved 8-word, latency 3
    run_burst("R4", 16'h18C2, 8'h0B, 0, 16);
    // R3 linear 4-word, latency 5
    run_burst("R3", 16'h2C49, 8'h06, 0, 14);
    // R5 two-cycle hold, 8 words
    run_burst("R5", 16'h2642, 8'h12, 0, 25);
    // R6 endless unaligned crossing 0x40
    run_burst("R6", 16'h1447, 8'h3D, 0, 16);
    // R6 endless aligned: no stall
    run_burst("R6", 16'h1447, 8'h3C, 0, 16);
    // R6 stall lasting two clocks
    run_burst("R6", 16'h1647, 8'h7E, 0, 16);
    // R4 interleave ignored with endless and with no-wrap
    run_burst("R4", 16'h14C7, 8'h05, 0, 14);
    run_burst("R4", 16'h14CA, 8'h0D, 0, 16);
    // R8 single read ignores length, order, hold
    run_burst("R8", 16'h16C2, 8'h0B, 1, 10);
    // R7 active-low WAIT
    run_burst("R7", 16'h1041, 8'h20, 0, 10);
    // R1 latency clamps
    run_burst("R1", 16'h3841, 8'h01, 0, 12);
    run_burst("R1", 16'h0041, 8'h02, 0, 12);
    // R2 other length code is endless; finite end checked above
    run_burst("R2", 16'h1443, 8'h30, 0, 12);
    // R9 abort during latency and during data
    run_burst("R9", 16'h2841, 8'h10, 0, 2);
    run_burst("R9", 16'h1442, 8'h18, 0, 4);
    // R12 address wraps modulo 2^AW with stall at 0x00
    run_burst("R12", 16'h1447, 8'hFE, 0, 12);
    // R10 restart mid-burst
    req = "R10"; cfg = 16'h1842; rd_addr = 8'h44; single_rd = 0;
    chip_sel_n = 1'b0; addr_strobe_n = 1'b0;
    step(); addr_strobe_n = 1'b1;
    step(5);
    rd_addr = 8'h91; addr_strobe_n = 1'b0;
    step(); addr_strobe_n = 1'b1;
    step(14);
    chip_sel_n = 1'b1;
    step(2);
    // R11 falling active edge, changed under reset
    req = "R11";
    rst_n = 1'b0; step();
    cfg = 16'h1401; step(2);
    rst_n = 1'b1; step(2);
    run_burst("R11", 16'h1401, 8'h09, 0, 12);
    run_burst("R11", 16'h1602, 8'h0E, 0, 20);
    rst_n = 1'b0; step();
    cfg = 16'h1441; step(2);
    rst_n = 1'b1; step(2);
    run_burst("R2", 16'h1441, 8'h07, 0, 10);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule